// File: doc/BRIEF.md
# Programmable Bank Address Remapper

This block sits between the on-chip requesters (cache refills, DMA engines) and the external memory interface. For every address it passes through, it swaps the bank field for a bank number read from a small remap table. The table is indexed by the address's original bank and its row. The row and column fields are not touched, so each page stays in its own row. Two pages that a program visits back to back can then be placed in different banks, and the precharge/activate cost of switching pages is hidden. Software running on the processor does not see the remap.

The table is loaded through a one-entry-per-cycle write port before the workload starts. After reset every entry holds its own bank number, so the block passes addresses through unchanged until it is programmed. A bypass input disables translation. Lookups pass through one register stage with valid/ready flow control. A flag reports when the row group most recently written holds the same bank number twice, which would mean the row is not a permutation.

The table is indexed by the bank and the low `MAP_ROW_W` bits of the row. Rows that share those bits share one set of entries. This keeps the storage at `BANKS << MAP_ROW_W` entries; setting `MAP_ROW_W` equal to the full row width gives one entry set per row.

Top module: `bankremap`

## Requirements
- R1: After reset, `outValid` is 0, `inReady` is 1 and `rowDup` is 0. Every table entry equals its own original bank, so a lookup returns its input address unchanged.
- R2: Address layout: the bank is the top `BANK_W` bits, the column is the low `COL_W` bits, and the row is the bits in between (default 2/12/10 of 24). The row and column bits of `outAddr` always equal those of the accepted input.
- R3: With `bypass` low, the bank bits of `outAddr` equal the table entry at index {original bank, low `MAP_ROW_W` row bits}.
- R4: Two rows whose low `MAP_ROW_W` bits are equal read the same table entries.
- R5: With `bypass` high when an address is accepted, `outAddr` equals that input address in full.
- R6: An address is accepted on a rising edge where `inValid` and `inReady` are both 1. `outValid` and the result appear right after that edge.
- R7: While `outValid` is 1 and `outReady` is 0, `outAddr` and `outValid` hold their values and `inReady` is 0.
- R8: While `wrEn` is 1, `inReady` is 0 and no lookup is accepted.
- R9: On each table write, `rowDup` updates to show whether the written row group, including the new entry, holds any bank number twice. `rowDup` changes only on a write.
- R10: A write of `wrData` at index {`wrBank`, `wrRow`} takes effect for every lookup accepted after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| bypass | input | 1 | Pass addresses through untranslated |
| wrEn | input | 1 | Table write strobe |
| wrBank | input | BANK_W | Original bank of the entry written |
| wrRow | input | MAP_ROW_W | Row group of the entry written |
| wrData | input | BANK_W | New bank number to store |
| inValid | input | 1 | Input address valid |
| inReady | output | 1 | Block can accept an address |
| inAddr | input | ADDR_W | Address from requester |
| outValid | output | 1 | Translated address valid |
| outReady | input | 1 | Downstream accepts the address |
| outAddr | output | ADDR_W | Translated address |
| rowDup | output | 1 | Last written row group maps two pages to one bank |

## Verification
A corrupted table entry changes only the top bank bits of lookups that hit that entry. The bench therefore sends addresses into programmed row groups, into aliased row groups and into untouched ones, and compares the whole address one cycle after acceptance. A wrong handshake state shows up at once as a lost or repeated address, or as an output that moves while stalled. A wrong duplicate flag is visible on the cycle after each write, during a two-step swap that first creates a duplicate and then clears it.

// File: rtl/bankremap_pkg.sv
package bankremap_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic wr;    // write table entry this cycle
    logic load;  // capture a lookup into the output stage
  } ctlStrobe_t;
endpackage

// File: rtl/bankremap_ctrl.sv
module bankremap_ctrl
  import bankremap_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic       inValid,
  input  logic       outReady,
  output logic       inReady,
  output logic       outValid,
  output ctlStrobe_t ctl
);
  logic validQ;

  // Table writes win over lookups; stage frees when drained or draining.
  assign inReady  = !wrEn && (!validQ || outReady);
  assign ctl.wr   = wrEn;
  assign ctl.load = inValid && inReady;
  assign outValid = validQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         validQ <= 1'b0;
    else if (ctl.load) validQ <= 1'b1;
    else if (outReady) validQ <= 1'b0;
  end
endmodule

// File: rtl/bankremap_dp.sv
module bankremap_dp
  import bankremap_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int BANKS     = 4,
  parameter int COL_W     = 10,
  parameter int MAP_ROW_W = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctlStrobe_t           ctl,
  input  logic                 bypass,
  input  logic [ADDR_W-1:0]    inAddr,
  input  logic [$clog2(BANKS)-1:0] wrBank,
  input  logic [MAP_ROW_W-1:0] wrRow,
  input  logic [$clog2(BANKS)-1:0] wrData,
  output logic [ADDR_W-1:0]    outAddr,
  output logic                 rowDup
);
  localparam int BANK_W = $clog2(BANKS);
  localparam int LOW_W  = ADDR_W - BANK_W;
  localparam int GROUPS = 1 << MAP_ROW_W;

  logic [BANK_W-1:0] tbl [BANKS][GROUPS];

  logic [BANK_W-1:0]    lkBank;
  logic [MAP_ROW_W-1:0] lkRow;
  logic [BANK_W-1:0]    newBank;
  logic [BANK_W-1:0]    rowView [BANKS];
  logic                 dupNext;

  assign lkBank  = inAddr[ADDR_W-1 -: BANK_W];
  assign lkRow   = inAddr[COL_W +: MAP_ROW_W];
  assign newBank = bypass ? lkBank : tbl[lkBank][lkRow];

  // Written row group as it will look after this write
  always_comb begin
    for (int b = 0; b < BANKS; b++)
      rowView[b] = (BANK_W'(b) == wrBank) ? wrData : tbl[b][wrRow];
    dupNext = 1'b0;
    for (int i = 0; i < BANKS; i++)
      for (int j = i + 1; j < BANKS; j++)
        if (rowView[i] == rowView[j]) dupNext = 1'b1;
  end

  // Table storage, identity after reset
  generate
    for (genvar b = 0; b < BANKS; b++) begin : g_bank
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          for (int g = 0; g < GROUPS; g++) tbl[b][g] <= BANK_W'(b);
        end else if (ctl.wr && wrBank == BANK_W'(b)) begin
          tbl[b][wrRow] <= wrData;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outAddr <= '0;
      rowDup  <= 1'b0;
    end else begin
      if (ctl.load) outAddr <= {newBank, inAddr[LOW_W-1:0]};
      if (ctl.wr)   rowDup  <= dupNext;
    end
  end
endmodule

// File: rtl/bankremap.sv
module bankremap
  import bankremap_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int BANKS     = 4,
  parameter int COL_W     = 10,
  parameter int MAP_ROW_W = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     bypass,
  input  logic                     wrEn,
  input  logic [$clog2(BANKS)-1:0] wrBank,
  input  logic [MAP_ROW_W-1:0]     wrRow,
  input  logic [$clog2(BANKS)-1:0] wrData,
  input  logic                     inValid,
  output logic                     inReady,
  input  logic [ADDR_W-1:0]        inAddr,
  output logic                     outValid,
  input  logic                     outReady,
  output logic [ADDR_W-1:0]        outAddr,
  output logic                     rowDup
);
  ctlStrobe_t ctl;

  bankremap_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .inValid(inValid),
    .outReady(outReady), .inReady(inReady), .outValid(outValid), .ctl(ctl)
  );

  bankremap_dp #(
    .ADDR_W(ADDR_W), .BANKS(BANKS), .COL_W(COL_W), .MAP_ROW_W(MAP_ROW_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .bypass(bypass), .inAddr(inAddr),
    .wrBank(wrBank), .wrRow(wrRow), .wrData(wrData),
    .outAddr(outAddr), .rowDup(rowDup)
  );
endmodule

// File: rtl/bankremap_chk.sv
module bankremap_chk #(
  parameter int ADDR_W = 24,
  parameter int BANKS  = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              bypass,
  input logic              wrEn,
  input logic              inValid,
  input logic              inReady,
  input logic [ADDR_W-1:0] inAddr,
  input logic              outValid,
  input logic              outReady,
  input logic [ADDR_W-1:0] outAddr,
  input logic              rowDup
);
  localparam int LOW_W = ADDR_W - $clog2(BANKS);

  // R8
  wr_blocks_lookup_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> !inReady);

  // R7
  stall_holds_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outAddr)));

  // R6
  accept_to_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> outValid);

  // R2
  low_bits_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> (outAddr[LOW_W-1:0] == $past(inAddr[LOW_W-1:0])));

  // R5
  bypass_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady && bypass) |=> (outAddr == $past(inAddr)));

  // R9
  dup_only_on_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rowDup != $past(rowDup)) |-> $past(wrEn));
endmodule

bind bankremap bankremap_chk #(.ADDR_W(ADDR_W), .BANKS(BANKS)) u_chk (
  .clk(clk), .rstN(rstN), .bypass(bypass), .wrEn(wrEn), .inValid(inValid),
  .inReady(inReady), .inAddr(inAddr), .outValid(outValid),
  .outReady(outReady), .outAddr(outAddr), .rowDup(rowDup)
);

// File: tb/bankremap_tb.sv
module bankremap_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        bypass = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrBank = '0;
  logic [7:0]  wrRow = '0;
  logic [1:0]  wrData = '0;
  logic        inValid = 1'b0;
  logic        inReady;
  logic [23:0] inAddr = '0;
  logic        outValid;
  logic        outReady = 1'b1;
  logic [23:0] outAddr;
  logic        rowDup;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  bankremap u_dut (
    .clk(clk), .rstN(rstN), .bypass(bypass), .wrEn(wrEn), .wrBank(wrBank),
    .wrRow(wrRow), .wrData(wrData), .inValid(inValid), .inReady(inReady),
    .inAddr(inAddr), .outValid(outValid), .outReady(outReady),
    .outAddr(outAddr), .rowDup(rowDup)
  );

  function automatic logic [23:0] mk(input logic [1:0] b, input logic [11:0] r,
                                     input logic [9:0] c);
    return {b, r, c};
  endfunction

  task automatic chk(input logic ok, input string tag,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tblWrite(input logic [1:0] b, input logic [7:0] r,
                          input logic [1:0] d, input logic expDup);
    @(negedge clk);
    wrEn = 1'b1; wrBank = b; wrRow = r; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
    chk(rowDup == expDup, "R9 rowDup", 32'(rowDup), 32'(expDup));
  endtask

  // Single lookup with outReady high; result checked one edge later
  task automatic lookup(input logic byp, input logic [23:0] a,
                        input logic [23:0] exp, input string tag);
    @(negedge clk);
    bypass = byp; inAddr = a; inValid = 1'b1;
    chk(inReady == 1'b1, "R6 inReady", 32'(inReady), 32'd1);
    @(negedge clk);
    inValid = 1'b0; bypass = 1'b0;
    chk(outValid == 1'b1, "R6 outValid", 32'(outValid), 32'd1);
    chk(outAddr == exp, tag, 32'(outAddr), 32'(exp));
  endtask

  // {bypass, bank, row, col, expected bank}
  localparam logic [26:0] VEC [8] = '{
    {1'b0, 2'd0, 12'h005, 10'h155, 2'd2},  // R3 programmed swap
    {1'b0, 2'd2, 12'h005, 10'h3FF, 2'd0},  // R3
    {1'b0, 2'd1, 12'h005, 10'h000, 2'd1},  // R3 unchanged entry
    {1'b0, 2'd3, 12'h003, 10'h2AA, 2'd1},  // R3 second group
    {1'b0, 2'd1, 12'h003, 10'h001, 2'd3},  // R3
    {1'b0, 2'd0, 12'h105, 10'h123, 2'd2},  // R4 aliased row
    {1'b1, 2'd0, 12'h005, 10'h155, 2'd0},  // R5 bypass
    {1'b0, 2'd3, 12'hFFF, 10'h3FF, 2'd3}   // R2 untouched group
  };

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [23:0] a1;
    logic [23:0] a2;
    repeat (3) @(negedge clk);
    chk(outValid == 1'b0, "R1 outValid", 32'(outValid), 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk(inReady == 1'b1, "R1 inReady", 32'(inReady), 32'd1);
    chk(outValid == 1'b0, "R1 outValid", 32'(outValid), 32'd0);
    chk(rowDup == 1'b0, "R1 rowDup", 32'(rowDup), 32'd0);
    lookup(1'b0, 24'hC12345, 24'hC12345, "R1 identity");

    // swap banks 0 and 2 in group 5; midway the row holds bank 2 twice
    tblWrite(2'd0, 8'h05, 2'd2, 1'b1);
    tblWrite(2'd2, 8'h05, 2'd0, 1'b0);
    // swap banks 1 and 3 in group 3
    tblWrite(2'd3, 8'h03, 2'd1, 1'b1);
    tblWrite(2'd1, 8'h03, 2'd3, 1'b0);

    for (int i = 0; i < 8; i++) begin
      lookup(VEC[i][26], mk(VEC[i][25:24], VEC[i][23:12], VEC[i][11:2]),
             mk(VEC[i][1:0], VEC[i][23:12], VEC[i][11:2]), "R3/R4/R5 vector");
    end

    // R7 backpressure
    a1 = mk(2'd2, 12'h005, 10'h011);
    a2 = mk(2'd0, 12'h003, 10'h022);
    @(negedge clk);
    outReady = 1'b0; inAddr = a1; inValid = 1'b1;
    @(negedge clk);
    inAddr = a2;
    chk(outValid == 1'b1, "R7 valid", 32'(outValid), 32'd1);
    chk(inReady == 1'b0, "R7 inReady", 32'(inReady), 32'd0);
    chk(outAddr == mk(2'd0, 12'h005, 10'h011), "R7 first",
        32'(outAddr), 32'(mk(2'd0, 12'h005, 10'h011)));
    @(negedge clk);
    chk(outAddr == mk(2'd0, 12'h005, 10'h011), "R7 held",
        32'(outAddr), 32'(mk(2'd0, 12'h005, 10'h011)));
    outReady = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    chk(outAddr == a2, "R7 second", 32'(outAddr), 32'(a2));
    @(negedge clk);
    chk(outValid == 1'b0, "R7 drained", 32'(outValid), 32'd0);

    // R8 write collides with lookup
    wrEn = 1'b1; wrBank = 2'd1; wrRow = 8'h09; wrData = 2'd1;
    inValid = 1'b1; inAddr = mk(2'd1, 12'h009, 10'h004);
    #1 chk(inReady == 1'b0, "R8 inReady", 32'(inReady), 32'd0);
    @(negedge clk);
    chk(outValid == 1'b0, "R8 stalled", 32'(outValid), 32'd0);
    chk(rowDup == 1'b0, "R9 rowDup clean", 32'(rowDup), 32'd0);
    wrEn = 1'b0;
    @(negedge clk);
    inValid = 1'b0;
    chk(outValid == 1'b1, "R8 resumed", 32'(outValid), 32'd1);
    chk(outAddr == mk(2'd1, 12'h009, 10'h004), "R8 addr",
        32'(outAddr), 32'(mk(2'd1, 12'h009, 10'h004)));

    // R10 new entry used by next lookup
    tblWrite(2'd0, 8'h07, 2'd3, 1'b1);
    lookup(1'b0, mk(2'd0, 12'h007, 10'h0AB), mk(2'd3, 12'h007, 10'h0AB), "R10 new entry");
    tblWrite(2'd3, 8'h07, 2'd0, 1'b0);
    lookup(1'b0, mk(2'd3, 12'h207, 10'h0CD), mk(2'd0, 12'h207, 10'h0CD), "R10 R4 alias");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule